// File: doc/BRIEF.md
# SD Command Issue Engine

This block sends one SD/MMC command over the single-wire CMD line and collects the card's reply. Software writes the 32-bit argument first. It then writes the command register with the command index, the response flags and the enable bit. That one write starts the command.

The engine forms the 48-bit command frame and appends a CRC7. It sends the frame by pulling an open-drain line low. It then waits a bounded time for the card's start bit. It receives either a 48-bit or a 136-bit response. It stores the payload words and the echoed index, and finishes with exactly one status bit set.

All shifting happens in the system clock domain. An external one-cycle SD clock enable strobe paces each bit. A self-clearing soft reset returns the whole engine to idle.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset every readable register (word offsets 0 to 28) reads 0 and `cmd_low_o` is 0.
- R2: A command goes out as 48 bits, MSB first, one bit per `sd_tick_i` strobe. The bits are: a 0, a 1, the 6-bit index, the 32-bit argument, a CRC7 and a final 1. The CRC7 uses x^7+x^3+1 with a zero start value and covers the first 40 bits. The line is driven only low (`cmd_low_o`=1 for a 0 bit).
- R3: The command register is at offset 0. Its fields are: index [5:0], need-response bit 6, long-response bit 7, app marker bit 8, enable bit 9 and soft reset bit 10. A write with bit 9 set while idle starts a command. Reading offset 0 returns the stored bits [8:0], with bit 9 high while the command runs.
- R4: A command without need-response ends after its end bit with only status bit 6 (sent) set.
- R5: After the end bit, the engine samples the line on each strobe. If the start bit (0) appears on any of the first 64 samples, the response is accepted. If 64 samples all read 1, only status bit 2 (timeout) is set, and the response registers and offset 24 are left unchanged.
- R6: A short response is 48 bits. Its bits [39:8] go to offset 8, and offsets 12 to 20 are left as they were. If its bits [7:1] match the CRC7 of its bits [47:8], status bit 4 (ok) is set; otherwise status bit 0 (CRC fail) is set.
- R7: A long response is 136 bits. Its last 128 bits fill offsets 8 (least significant word) through 20 (most significant). No CRC check is made, and status bit 4 is set.
- R8: Offset 24 holds the 6 response bits that follow the transmission bit in [5:0], and the issued command's app marker in bit 6. It is updated only when a response is received.
- R9: The status register is at offset 28, with bits 0, 2, 4 and 6. Issuing a command clears it. At most one of these bits is ever set.
- R10: A write to offset 0 while a command runs is ignored. The frame on the line and the stored flags do not change, and no second command follows.
- R11: Writing bit 10 at offset 0 makes bit 10 read 1 for RST_CYCLES clocks and then 0. It aborts any command, releases the line and clears every register to 0.
- R12: The argument register at offset 4 reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_tick_i | input | 1 | One-cycle SD clock enable strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| cmd_i | input | 1 | Sensed level of the CMD line |
| cmd_low_o | output | 1 | Pull the CMD line low when 1 |

## Verification
A bad bit counter or shift position shows up on the line within one strobe, as a frame bit that differs from the CRC-bearing frame the bench computes. A wrong response or timeout counter appears as the wrong status bit, or as words stored at the wrong offsets, at the end of that command. The 63 and 64 sample cases pin down the timeout bound to within one strobe. A reset or busy flag that goes stale shows at the very next register read or strobe. It appears as a line still pulled low, a flag that changed, or a second frame starting.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int FRAME_W = 48;
  localparam int LONG_W  = 136;
  localparam int MSG_W   = 40;

  typedef enum logic [2:0] {RX_IDLE, RX_WAIT, RX_BITS, RX_FIN, RX_TOUT} rx_state_e;

  // serial CRC7, x^7 + x^3 + 1, zero seed
  function automatic logic [6:0] crc7_calc(input logic [MSG_W-1:0] msg);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      fb = msg[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        tick_i,
  input  logic        start_i,
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  output logic        cmd_low_o,
  output logic        done_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               act_q;
  logic [MSG_W-1:0]   msg;

  assign msg = {2'b01, idx_i, arg_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      act_q   <= 1'b0;
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      act_q   <= 1'b1;
      frame_q <= {msg, crc7_calc(msg), 1'b1};
      cnt_q   <= '0;
    end else if (act_q && tick_i) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
      end else begin
        frame_q <= frame_q << 1;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign cmd_low_o = act_q & ~frame_q[FRAME_W-1];
  assign done_o    = act_q & tick_i & (cnt_q == LAST);

  // R2: the start bit is driven low straight after issue
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> cmd_low_o);
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              long_i,
  input  logic              cmd_i,
  output logic              done_o,
  output logic              tout_o,
  output logic              crc_bad_o,
  output logic [LONG_W-1:0] shift_o
);
  localparam int TO_W  = $clog2(TIMEOUT_TICKS + 1);
  localparam int BIT_W = $clog2(LONG_W + 1);
  localparam logic [TO_W-1:0]  TO_LAST    = TO_W'(TIMEOUT_TICKS - 1);
  localparam logic [BIT_W-1:0] SHORT_LAST = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] LONG_LAST  = BIT_W'(LONG_W - 1);

  rx_state_e         st_q;
  logic [TO_W-1:0]   to_q;
  logic [BIT_W-1:0]  nb_q;
  logic              long_q;
  logic [LONG_W-1:0] sh_q;
  logic [BIT_W-1:0]  last_bit;

  assign last_bit = long_q ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RX_IDLE; to_q <= '0; nb_q <= '0; long_q <= 1'b0; sh_q <= '0;
    end else if (clr_i) begin
      st_q <= RX_IDLE; to_q <= '0; nb_q <= '0; long_q <= 1'b0; sh_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: if (start_i) begin
          st_q <= RX_WAIT; to_q <= '0; long_q <= long_i; sh_q <= '0;
        end
        RX_WAIT: if (tick_i) begin
          if (!cmd_i) begin
            sh_q <= {sh_q[LONG_W-2:0], 1'b0};
            nb_q <= BIT_W'(1);
            st_q <= RX_BITS;
          end else if (to_q == TO_LAST) begin
            st_q <= RX_TOUT;
          end else begin
            to_q <= to_q + 1'b1;
          end
        end
        RX_BITS: if (tick_i) begin
          sh_q <= {sh_q[LONG_W-2:0], cmd_i};
          nb_q <= nb_q + 1'b1;
          if (nb_q == last_bit) st_q <= RX_FIN;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o    = (st_q == RX_FIN) || (st_q == RX_TOUT);
  assign tout_o    = (st_q == RX_TOUT);
  assign crc_bad_o = (st_q == RX_FIN) && !long_q &&
                     (sh_q[7:1] != crc7_calc(sh_q[FRAME_W-1:8]));
  assign shift_o   = sh_q;

  // R5: the wait counter never passes the timeout bound
  a_r5_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_WAIT) |-> (to_q <= TO_LAST));
  // R9: completion is a single-cycle event
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int TIMEOUT_TICKS = 64,
  parameter int RST_CYCLES    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              cmd_i,
  output logic              cmd_low_o
);
  localparam int WW   = ADDR_W - 2;
  localparam int RW   = $clog2(RST_CYCLES + 1);
  localparam int NRSP = 4;

  logic [31:0]           arg_q;
  logic [8:0]            flags_q;
  logic                  busy_q;
  logic                  st_fail_q, st_tout_q, st_ok_q, st_sent_q;
  logic [NRSP-1:0][31:0] rsp_q;
  logic [6:0]            rspcmd_q;
  logic [RW-1:0]         srst_q;

  logic [WW-1:0]     wr_word, rd_word;
  logic              srst_act, wr_cmd, wr_arg, issue, srst_go, clr;
  logic              tx_done, rx_done, rx_tout, rx_bad;
  logic [LONG_W-1:0] rx_sh;

  assign wr_word  = wr_addr_i[ADDR_W-1:2];
  assign rd_word  = rd_addr_i[ADDR_W-1:2];
  assign srst_act = (srst_q != '0);
  assign wr_cmd   = wr_en_i && (wr_word == WW'(0)) && !srst_act;
  assign wr_arg   = wr_en_i && (wr_word == WW'(1)) && !srst_act;
  assign srst_go  = wr_cmd && wr_data_i[10];
  assign issue    = wr_cmd && wr_data_i[9] && !wr_data_i[10] && !busy_q;
  assign clr      = srst_go || srst_act;

  sd_cmd_tx u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .tick_i    (sd_tick_i),
    .start_i   (issue),
    .idx_i     (wr_data_i[5:0]),
    .arg_i     (arg_q),
    .cmd_low_o (cmd_low_o),
    .done_o    (tx_done)
  );

  sd_cmd_rx #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .tick_i    (sd_tick_i),
    .start_i   (tx_done && flags_q[6]),
    .long_i    (flags_q[7]),
    .cmd_i     (cmd_i),
    .done_o    (rx_done),
    .tout_o    (rx_tout),
    .crc_bad_o (rx_bad),
    .shift_o   (rx_sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q <= '0; flags_q <= '0; busy_q <= 1'b0; rsp_q <= '0; rspcmd_q <= '0;
      st_fail_q <= 1'b0; st_tout_q <= 1'b0; st_ok_q <= 1'b0; st_sent_q <= 1'b0;
      srst_q <= '0;
    end else if (clr) begin
      arg_q <= '0; flags_q <= '0; busy_q <= 1'b0; rsp_q <= '0; rspcmd_q <= '0;
      st_fail_q <= 1'b0; st_tout_q <= 1'b0; st_ok_q <= 1'b0; st_sent_q <= 1'b0;
      srst_q <= srst_go ? RW'(RST_CYCLES) : srst_q - RW'(1);
    end else begin
      if (wr_arg) arg_q <= wr_data_i;
      if (issue) begin
        flags_q   <= wr_data_i[8:0];
        busy_q    <= 1'b1;
        st_fail_q <= 1'b0; st_tout_q <= 1'b0; st_ok_q <= 1'b0; st_sent_q <= 1'b0;
      end
      if (tx_done && !flags_q[6]) begin
        st_sent_q <= 1'b1;
        busy_q    <= 1'b0;
      end
      if (rx_done) begin
        busy_q <= 1'b0;
        if (rx_tout) begin
          st_tout_q <= 1'b1;
        end else begin
          st_fail_q <= rx_bad;
          st_ok_q   <= !rx_bad;
          if (flags_q[7]) begin
            for (int i = 0; i < NRSP; i++) rsp_q[i] <= rx_sh[32*i +: 32];
            rspcmd_q <= {flags_q[8], rx_sh[133:128]};
          end else begin
            rsp_q[0] <= rx_sh[39:8];
            rspcmd_q <= {flags_q[8], rx_sh[45:40]};
          end
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_word)
      WW'(0): rd_data_o = {21'b0, srst_act, busy_q, flags_q};
      WW'(1): rd_data_o = arg_q;
      WW'(2): rd_data_o = rsp_q[0];
      WW'(3): rd_data_o = rsp_q[1];
      WW'(4): rd_data_o = rsp_q[2];
      WW'(5): rd_data_o = rsp_q[3];
      WW'(6): rd_data_o = {25'b0, rspcmd_q};
      WW'(7): rd_data_o = {25'b0, st_sent_q, 1'b0, st_ok_q, 1'b0, st_tout_q, 1'b0, st_fail_q};
      default: rd_data_o = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[31:11], wr_addr_i[1:0], rd_addr_i[1:0], rx_sh[135:134]};

  // R9: never more than one completion status bit
  a_r9_one_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({st_fail_q, st_tout_q, st_ok_q, st_sent_q}));
  // R11: line released throughout soft reset
  a_r11_line_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_act |-> !cmd_low_o);
  // R4: sent status only for commands without response
  a_r4_sent_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_sent_q) |-> !flags_q[6]);
  // R10: a command write while busy leaves the flags alone
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_cmd && !wr_data_i[10]) |=> $stable(flags_q));
endmodule

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;
  localparam int RST_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sd_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cmd_low;
  logic        card_q = 1'b1;
  logic        cmd_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  // phy model state
  bit           phy_on = 1'b0;
  int           smp = 0;
  int           dly = 0;
  int           rlen = 0;
  logic [135:0] rbits = '0;
  logic [47:0]  cap = '0;

  assign cmd_line = card_q & ~cmd_low;

  always #5 clk = ~clk;

  sd_cmd_engine #(.ADDR_W(5), .TIMEOUT_TICKS(64), .RST_CYCLES(RST_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sd_tick_i(sd_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cmd_i(cmd_line), .cmd_low_o(cmd_low)
  );

  // strobe every 4th clock; host capture and card drive on the negedge before it
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      sd_tick = (ph == 0);
      if (sd_tick && phy_on) begin
        if (smp < 48) begin
          cap[47 - smp] = ~cmd_low;
          card_q = 1'b1;
        end else begin
          int j;
          j = smp - 48;
          if (j < dly) card_q = 1'b1;
          else if (j - dly < rlen) card_q = rbits[rlen - 1 - (j - dly)];
          else card_q = 1'b1;
        end
        smp++;
      end else if (!phy_on) begin
        card_q = 1'b1;
      end
    end
  end

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [6:0] r;
    r = 7'h00;
    for (int k = 39; k >= 0; k--) begin
      if (m[k] != r[6]) r = (r << 1) ^ 7'b0001001;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] a);
    return {2'b01, idx, a, ref_crc({2'b01, idx, a}), 1'b1};
  endfunction

  function automatic logic [47:0] ref_short(input logic [5:0] idx, input logic [31:0] p);
    return {2'b00, idx, p, ref_crc({2'b00, idx, p}), 1'b1};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n;
    n = 0;
    v = 32'h600;
    while ((v[10:9] != 2'b00) && n < 5000) begin
      rd(5'd0, v);
      n++;
    end
    if (n >= 5000) begin
      n_chk++; n_fail++;
      $display("FAIL R3 command never finished actual=%h expected=0", v);
    end
    phy_on = 1'b0;
  endtask

  // issue: argument first, then command word; phy counting starts after the issuing edge
  task automatic issue(input logic [5:0] idx, input logic need, input logic lng,
                       input logic app, input logic [31:0] a, input int d,
                       input logic [135:0] rb, input int rl);
    wr(5'd4, a);
    dly = d; rbits = rb; rlen = rl;
    wr(5'd0, {21'b0, 1'b0, 1'b1, app, lng, need, idx});
    smp = 0; phy_on = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v);
      chk("R1 reset register", {32'b0, v}, 64'h0);
    end
    chk("R1 line released", {63'b0, cmd_low}, 64'h0);
  endtask

  task automatic t_arg();
    logic [31:0] v;
    wr(5'd4, 32'hA5C3_0F96);
    rd(5'd4, v);
    chk("R12 argument readback", {32'b0, v}, {32'b0, 32'hA5C3_0F96});
  endtask

  task automatic t_no_rsp();
    logic [31:0] v;
    issue(6'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 0, '0, 0);
    rd(5'd0, v);
    chk("R3 busy readback", {32'b0, v}, 64'h200);
    wait_idle();
    chk("R2 frame CMD0", {16'b0, cap}, {16'b0, ref_frame(6'd0, 32'h0)});
    rd(5'd28, v);
    chk("R4 sent status", {32'b0, v}, 64'h40);
    rd(5'd0, v);
    chk("R3 idle readback", {32'b0, v}, 64'h0);
  endtask

  task automatic t_short_ok();
    logic [31:0] v;
    issue(6'd17, 1'b1, 1'b0, 1'b0, 32'h1234_5678, 5,
          {88'b0, ref_short(6'd17, 32'hCAFE_F00D)}, 48);
    wait_idle();
    chk("R2 frame idx17", {16'b0, cap}, {16'b0, ref_frame(6'd17, 32'h1234_5678)});
    rd(5'd28, v);
    chk("R6 crc ok status", {32'b0, v}, 64'h10);
    rd(5'd8, v);
    chk("R6 short payload", {32'b0, v}, {32'b0, 32'hCAFE_F00D});
    rd(5'd24, v);
    chk("R8 short index", {32'b0, v}, 64'h11);
  endtask

  task automatic t_short_bad();
    logic [31:0] v;
    issue(6'd13, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 2,
          {88'b0, ref_short(6'd13, 32'h0BAD_0BAD) ^ 48'h2}, 48);
    wait_idle();
    rd(5'd28, v);
    chk("R6 crc fail status", {32'b0, v}, 64'h01);
    rd(5'd24, v);
    chk("R8 index on crc fail", {32'b0, v}, 64'h0D);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    issue(6'd9, 1'b1, 1'b0, 1'b0, 32'hFFFF_0000, 64,
          {88'b0, ref_short(6'd9, 32'h7777_7777)}, 48);
    wait_idle();
    rd(5'd28, v);
    chk("R5 timeout at 64 samples", {32'b0, v}, 64'h04);
    rd(5'd8, v);
    chk("R5 response kept on timeout", {32'b0, v}, {32'b0, 32'h0BAD_0BAD});
    rd(5'd24, v);
    chk("R8 index kept on timeout", {32'b0, v}, 64'h0D);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    issue(6'd9, 1'b1, 1'b0, 1'b0, 32'hFFFF_0000, 63,
          {88'b0, ref_short(6'd9, 32'h7777_7777)}, 48);
    wait_idle();
    rd(5'd28, v);
    chk("R5 start bit on sample 64", {32'b0, v}, 64'h10);
    rd(5'd8, v);
    chk("R5 late response stored", {32'b0, v}, {32'b0, 32'h7777_7777});
  endtask

  task automatic t_long();
    logic [31:0]  v;
    logic [127:0] p;
    p = {32'hA1B2_C3D4, 32'h5566_7788, 32'h0BAD_CAFE, 32'h1357_9BDF};
    issue(6'd2, 1'b1, 1'b1, 1'b1, 32'h0, 3, {2'b00, 6'h3F, p}, 136);
    wait_idle();
    rd(5'd28, v);
    chk("R7 long status ok", {32'b0, v}, 64'h10);
    rd(5'd8, v);  chk("R7 word0", {32'b0, v}, {32'b0, p[31:0]});
    rd(5'd12, v); chk("R7 word1", {32'b0, v}, {32'b0, p[63:32]});
    rd(5'd16, v); chk("R7 word2", {32'b0, v}, {32'b0, p[95:64]});
    rd(5'd20, v); chk("R7 word3", {32'b0, v}, {32'b0, p[127:96]});
    rd(5'd24, v);
    chk("R8 long index with app", {32'b0, v}, 64'h7F);
  endtask

  task automatic t_short_keeps();
    logic [31:0] v;
    issue(6'd7, 1'b1, 1'b0, 1'b0, 32'h0000_00AA, 1,
          {88'b0, ref_short(6'd7, 32'h2468_ACE0)}, 48);
    wait_idle();
    rd(5'd8, v);  chk("R6 short word0", {32'b0, v}, {32'b0, 32'h2468_ACE0});
    rd(5'd12, v); chk("R6 word1 untouched", {32'b0, v}, {32'b0, 32'h0BAD_CAFE});
    rd(5'd20, v); chk("R6 word3 untouched", {32'b0, v}, {32'b0, 32'hA1B2_C3D4});
    rd(5'd24, v); chk("R8 app cleared", {32'b0, v}, 64'h07);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    issue(6'd5, 1'b0, 1'b0, 1'b0, 32'h3C3C_5A5A, 0, '0, 0);
    repeat (40) @(posedge clk);
    wr(5'd0, 32'h0000_03C9);  // enable idx 9, all flags, while busy
    wait_idle();
    chk("R10 frame unchanged", {16'b0, cap}, {16'b0, ref_frame(6'd5, 32'h3C3C_5A5A)});
    rd(5'd0, v);
    chk("R10 flags unchanged", {32'b0, v}, 64'h05);
    repeat (300) @(posedge clk);
    rd(5'd0, v);
    chk("R10 no second command", {32'b0, v}, 64'h05);
    chk("R10 line idle", {63'b0, cmd_low}, 64'h0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    issue(6'd1, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 0, '0, 0);
    repeat (30) @(posedge clk);
    wr(5'd0, 32'h0000_0400);
    rd(5'd0, v);
    chk("R11 reset bit reads 1", {32'b0, v}, 64'h400);
    chk("R11 line released", {63'b0, cmd_low}, 64'h0);
    phy_on = 1'b0;
    repeat (RST_CYC + 2) @(posedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v);
      chk("R11 register cleared", {32'b0, v}, 64'h0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_arg();
    t_no_rsp();
    t_short_ok();
    t_short_bad();
    t_timeout();
    t_edge();
    t_long();
    t_short_keeps();
    t_busy_ignore();
    t_srst();
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule